// File: doc/BRIEF.md
# Flash-to-Memory Read DMA Engine

This block copies a contiguous, 16-byte aligned range of serial flash into system memory without processor involvement. Software programs a flash source address, a destination start address and a destination end address through a small register port, then sets a start bit. The engine walks the range one 16-byte beat at a time. For each beat it sends a read command to a flash read front end, collects the 16 returned bytes into one 128-bit word, and writes that word through a valid/ready memory port.

The length is not a count. It is the span between the destination start and the destination end. When the final beat has been accepted, the start bit drops back to zero and a sticky completion flag is raised. That flag drives the interrupt line whenever its enable bit is also set, and software clears it by writing ones. The flash read command can be a plain read or a fast read with dummy clocks, and it can carry three or four address bytes. Both choices come from a configuration register.

The flash front end sends back exactly 16 bytes per request, on a byte stream that the engine can pause. The engine pauses that stream while the memory port holds a beat back, so no byte is ever dropped.

Top module: `flash_read_dma`

## Requirements
- R1: After reset the control register reads 0, the status and enable registers read 0, `irq` is low, and neither `fl_req_valid` nor `mem_valid` is asserted.
- R2: Register offsets are: 0 control (bit 0 = start/busy), 1 flash source, 2 destination start, 3 destination end, 4 interrupt status, 5 interrupt enable, 6 configuration. A started transfer issues one 16-byte flash request per beat, with the source address rising by 16 from one request to the next. It writes beats to destination start, start+16, and so on, stopping after the beat whose next address reaches the destination end.
- R3: Byte k of the 16 bytes returned for a request, counted from 0, is placed in bits [8k+7:8k] of the written beat.
- R4: The control register bit 0 reads 1 from the cycle after a valid start until the final beat is accepted, and reads 0 after that.
- R5: Completion of a transfer sets status bit 7. `irq` is high exactly while status bit 7 and enable bit 7 are both 1.
- R6: Writing the status register clears each status bit whose written bit is 1. Bits written as 0 keep their value. A completion in the same cycle as such a write wins.
- R7: With configuration bit 0 clear, each request carries opcode 0x03 and 0 dummy clocks. With it set, each request carries opcode 0x0B and 8 dummy clocks.
- R8: With configuration bit 1 set, `fl_req_addr4` is 1 and the full 32-bit source address is sent. With it clear, `fl_req_addr4` is 0 and bits 31:24 of the request address are zero.
- R9: A start while the aligned destination end is not above the aligned destination start issues no flash request and no memory write. The control bit reads 0 on the next cycle, and status bit 7 is not set.
- R10: While `mem_valid` is high and `mem_ready` is low, `fl_byte_ready` stays low and `mem_addr`/`mem_data` hold their values, so every byte returned by the flash front end reaches memory.
- R11: Bits 3:0 of the source, destination start and destination end registers are ignored: the transfer uses those addresses rounded down to a multiple of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fl_req_valid | output | 1 | Flash read request valid |
| fl_req_ready | input | 1 | Flash front end accepts the request |
| fl_req_opcode | output | 8 | Read opcode to send |
| fl_req_dummy | output | 4 | Dummy clocks before data |
| fl_req_addr4 | output | 1 | 1 = send four address bytes, 0 = three |
| fl_req_addr | output | 32 | Flash byte address of the request |
| fl_byte_valid | input | 1 | Returned flash byte valid |
| fl_byte_data | input | 8 | Returned flash byte |
| fl_byte_ready | output | 1 | Engine accepts a returned byte |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Destination byte address of the beat |
| mem_data | output | 128 | Beat data, little-endian byte order |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets unaligned register values, where an engine that did not mask the low bits would write to misaligned addresses or run one beat too many. It covers a destination end equal to the start, where a design using a count-down without a guard would wrap and stream a huge range, and a start above the end. It holds the memory port stalled for many cycles to catch a design that keeps pulling flash bytes and overwrites a pending beat. It also covers three-byte addressing with a high source address, which exposes an engine that forgets to clear the top address byte, and write-one-to-clear with zero bits, which exposes status logic that clears everything on any write.

// File: rtl/flash_read_dma.sv
module flash_read_dma #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic [2:0]              reg_addr,
  input  logic [AW-1:0]           reg_wdata,
  output logic [AW-1:0]           reg_rdata,
  output logic                    fl_req_valid,
  input  logic                    fl_req_ready,
  output logic [7:0]              fl_req_opcode,
  output logic [3:0]              fl_req_dummy,
  output logic                    fl_req_addr4,
  output logic [AW-1:0]           fl_req_addr,
  input  logic                    fl_byte_valid,
  input  logic [7:0]              fl_byte_data,
  output logic                    fl_byte_ready,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [AW-1:0]           mem_addr,
  output logic [BEAT_BYTES*8-1:0] mem_data,
  output logic                    irq
);
  localparam int BW = BEAT_BYTES * 8;
  localparam int CW = $clog2(BEAT_BYTES);
  localparam logic [AW-1:0] LOW_MASK = AW'(BEAT_BYTES - 1);
  localparam logic [AW-1:0] A24_MASK = AW'(32'h00FF_FFFF);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RECV, S_WR} st_t;

  st_t            state;
  logic [AW-1:0]  src_r, dst_r, end_r;
  logic [AW-1:0]  cur_src, cur_dst, cur_end;
  logic [7:0]     stat, ien;
  logic [1:0]     cfg;
  logic           busy;
  logic [BW-1:0]  beat;
  logic [CW-1:0]  cnt;

  wire start_wr = reg_wr_en && reg_addr == 3'd0 && reg_wdata[0] && state == S_IDLE;
  wire go       = start_wr && ((end_r & ~LOW_MASK) > (dst_r & ~LOW_MASK));
  wire wr_fire  = state == S_WR && mem_ready;
  wire last     = cur_dst + AW'(BEAT_BYTES) >= cur_end;
  wire done     = wr_fire && last;

  assign fl_req_valid  = state == S_REQ;
  assign fl_req_opcode = cfg[0] ? 8'h0B : 8'h03;
  assign fl_req_dummy  = cfg[0] ? 4'd8 : 4'd0;
  assign fl_req_addr4  = cfg[1];
  assign fl_req_addr   = cfg[1] ? cur_src : (cur_src & A24_MASK);
  assign fl_byte_ready = state == S_RECV;
  assign mem_valid     = state == S_WR;
  assign mem_addr      = cur_dst;
  assign mem_data      = beat;
  assign irq           = stat[7] & ien[7];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = AW'(busy);
      3'd1:    reg_rdata = src_r;
      3'd2:    reg_rdata = dst_r;
      3'd3:    reg_rdata = end_r;
      3'd4:    reg_rdata = AW'(stat);
      3'd5:    reg_rdata = AW'(ien);
      3'd6:    reg_rdata = AW'(cfg);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      src_r   <= '0;
      dst_r   <= '0;
      end_r   <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_end <= '0;
      stat    <= '0;
      ien     <= '0;
      cfg     <= '0;
      busy    <= 1'b0;
      beat    <= '0;
      cnt     <= '0;
    end else begin
      if (reg_wr_en) begin
        case (reg_addr)
          3'd1: src_r <= reg_wdata;
          3'd2: dst_r <= reg_wdata;
          3'd3: end_r <= reg_wdata;
          3'd4: stat  <= stat & ~reg_wdata[7:0];
          3'd5: ien   <= reg_wdata[7:0];
          3'd6: cfg   <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (done) stat[7] <= 1'b1;

      case (state)
        S_IDLE: if (go) begin
          cur_src <= src_r & ~LOW_MASK;
          cur_dst <= dst_r & ~LOW_MASK;
          cur_end <= end_r & ~LOW_MASK;
          busy    <= 1'b1;
          state   <= S_REQ;
        end
        S_REQ: if (fl_req_ready) begin
          cnt   <= '0;
          state <= S_RECV;
        end
        S_RECV: if (fl_byte_valid) begin
          beat[int'(cnt)*8 +: 8] <= fl_byte_data;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(BEAT_BYTES - 1)) state <= S_WR;
        end
        S_WR: if (mem_ready) begin
          cur_src <= cur_src + AW'(BEAT_BYTES);
          cur_dst <= cur_dst + AW'(BEAT_BYTES);
          if (last) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && !fl_req_ready |=> fl_req_valid && $stable(fl_req_addr)); // R2
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R10
  AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_byte_ready |-> busy); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stat[7]); // R5
  AST_OPCODE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid |-> (fl_req_opcode == 8'h03 && fl_req_dummy == 4'd0) ||
                     (fl_req_opcode == 8'h0B && fl_req_dummy == 4'd8)); // R7
  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[CW-1:0] == '0); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_req_valid && !mem_valid); // R9
endmodule

// File: tb/tb_flash_read_dma.sv
module tb_flash_read_dma;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic fl_req_valid, fl_req_ready = 1'b0;
  logic [7:0] fl_req_opcode;
  logic [3:0] fl_req_dummy;
  logic fl_req_addr4;
  logic [31:0] fl_req_addr;
  logic fl_byte_valid = 1'b0;
  logic [7:0] fl_byte_data = '0;
  logic fl_byte_ready;
  logic mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [127:0] mem_data;
  logic irq;

  flash_read_dma dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0, req_seen = 0;
  bit stall = 1'b0, finished = 1'b0;
  logic [7:0] exp_op = 8'h03;
  logic [3:0] exp_dm = 4'd0;
  logic exp_a4 = 1'b0;
  logic [31:0]  q_req[$];
  logic [31:0]  q_maddr[$];
  logic [127:0] q_mdata[$];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], 3'b0} ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  // flash model + scoreboard monitor, all at the falling edge
  logic s_reqv = 0, s_bready = 0, s_memv = 0, d_reqr = 0, d_bv = 0, d_memr = 0;
  logic [31:0] s_reqa, s_maddr, st_addr;
  logic [127:0] s_mdata;
  logic [7:0] s_op;
  logic [3:0] s_dm;
  logic s_a4;
  int st_idx = 0, st_left = 0;

  always @(negedge clk) begin
    if (s_memv && d_memr) begin
      if (q_maddr.size() == 0) check(1'b0, "R2 unexpected beat", s_maddr, 0);
      else begin
        logic [31:0] ea;
        logic [127:0] ed;
        ea = q_maddr.pop_front();
        ed = q_mdata.pop_front();
        check(s_maddr == ea, "R2/R11 beat address", s_maddr, ea);
        check(s_mdata == ed, "R3 beat data", s_mdata, ed);
      end
    end
    if (d_bv && s_bready) begin
      st_idx++;
      st_left--;
    end
    if (s_reqv && d_reqr) begin
      req_seen++;
      if (q_req.size() == 0) check(1'b0, "R9 unexpected request", s_reqa, 0);
      else begin
        logic [31:0] er;
        er = q_req.pop_front();
        check(s_reqa == er, "R8/R2 request address", s_reqa, er);
      end
      check(s_op == exp_op && s_dm == exp_dm, "R7 opcode/dummy", {s_op, s_dm}, {exp_op, exp_dm});
      check(s_a4 == exp_a4, "R8 address mode", s_a4, exp_a4);
      st_addr = s_reqa;
      st_idx = 0;
      st_left = 16;
    end
    mem_ready    = !stall && ($urandom % 4 != 0);
    fl_req_ready = ($urandom % 3 != 0);
    fl_byte_valid = (st_left > 0) && ($urandom % 4 != 0);
    fl_byte_data  = pat(st_addr + 32'(st_idx));
    d_memr = mem_ready; d_reqr = fl_req_ready; d_bv = fl_byte_valid;
    s_reqv = fl_req_valid; s_reqa = fl_req_addr; s_op = fl_req_opcode; s_dm = fl_req_dummy; s_a4 = fl_req_addr4;
    s_bready = fl_byte_ready;
    s_memv = mem_valid; s_maddr = mem_addr; s_mdata = mem_data;
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic xfer_start(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] en, input logic [1:0] c);
    logic [31:0] s, d, e, ra, rd;
    logic [127:0] bt;
    s = src & ~32'hF; d = dst & ~32'hF; e = en & ~32'hF;
    exp_op = c[0] ? 8'h0B : 8'h03;
    exp_dm = c[0] ? 4'd8 : 4'd0;
    exp_a4 = c[1];
    for (int b = 0; d + 32'(16*b) < e; b++) begin
      ra = s + 32'(16*b);
      if (!c[1]) ra = ra & 32'h00FF_FFFF;
      for (int k = 0; k < 16; k++) bt[8*k +: 8] = pat(ra + 32'(k));
      q_req.push_back(ra);
      q_maddr.push_back(d + 32'(16*b));
      q_mdata.push_back(bt);
    end
    reg_write(3'd6, {30'b0, c});
    reg_write(3'd1, src);
    reg_write(3'd2, dst);
    reg_write(3'd3, en);
    reg_write(3'd0, 32'h1);
    reg_read(3'd0, rd);
    if (e > d) check(rd[0] == 1'b1, "R4 busy after start", rd, 1);
  endtask

  task automatic xfer_wait();
    logic [31:0] rd;
    for (int i = 0; i < 5000; i++) begin
      reg_read(3'd0, rd);
      if (rd[0] == 1'b0) break;
    end
    check(rd[0] == 1'b0, "R4 busy clears at end", rd, 0);
    repeat (3) @(negedge clk);
    check(q_maddr.size() == 0 && q_req.size() == 0, "R2 all beats written",
          q_maddr.size(), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_read(3'd0, rd); check(rd == 0, "R1 control after reset", rd, 0);
    reg_read(3'd4, rd); check(rd == 0, "R1 status after reset", rd, 0);
    reg_read(3'd5, rd); check(rd == 0, "R1 enable after reset", rd, 0);
    check(irq == 0 && fl_req_valid == 0 && mem_valid == 0, "R1 outputs idle",
          {irq, fl_req_valid, mem_valid}, 0);

    // R2 R3 R7: plain read, 3-byte addressing, four beats
    xfer_start(32'h0000_1000, 32'h0000_8000, 32'h0000_8040, 2'b00);
    xfer_wait();
    reg_read(3'd4, rd); check(rd == 32'h80, "R5 status bit 7 set on completion", rd, 32'h80);
    check(irq == 0, "R5 irq masked by enable", irq, 0);
    reg_write(3'd5, 32'h80);
    #1 check(irq == 1, "R5 irq when enabled", irq, 1);
    reg_write(3'd4, 32'h00);
    reg_read(3'd4, rd); check(rd == 32'h80, "R6 zero write keeps status", rd, 32'h80);
    reg_write(3'd4, 32'h80);
    reg_read(3'd4, rd); check(rd == 0, "R6 one write clears status", rd, 0);
    check(irq == 0, "R5 irq drops after clear", irq, 0);

    // R7 R8: fast read, 4-byte address
    xfer_start(32'h0123_4560, 32'h0000_0100, 32'h0000_0130, 2'b11);
    xfer_wait();
    check(irq == 1, "R5 irq after fast read", irq, 1);
    reg_write(3'd4, 32'hFF);

    // R8: 3-byte mode with high source bits
    xfer_start(32'h0AB0_0020, 32'h0000_2000, 32'h0000_2020, 2'b00);
    xfer_wait();
    reg_write(3'd4, 32'hFF);

    // R11: unaligned registers
    xfer_start(32'h0000_0205, 32'h0000_3009, 32'h0000_3025, 2'b01);
    xfer_wait();
    reg_write(3'd4, 32'hFF);

    // R10: long memory stall
    stall = 1'b1;
    xfer_start(32'h0000_4000, 32'h0000_5000, 32'h0000_5020, 2'b00);
    for (int i = 0; i < 500 && !mem_valid; i++) @(negedge clk);
    held = mem_addr;
    repeat (25) @(negedge clk);
    check(mem_valid == 1 && fl_byte_ready == 0, "R10 stream paused during stall",
          {mem_valid, fl_byte_ready}, 2'b10);
    check(mem_addr == held, "R10 beat address held", mem_addr, held);
    stall = 1'b0;
    xfer_wait();
    reg_write(3'd4, 32'hFF);

    // R9: end equal to start, then end below start
    n0 = req_seen;
    xfer_start(32'h0000_6000, 32'h0000_7000, 32'h0000_7000, 2'b00);
    reg_read(3'd0, rd); check(rd == 0, "R9 start bit clears (equal)", rd, 0);
    xfer_start(32'h0000_6000, 32'h0000_7040, 32'h0000_7010, 2'b00);
    reg_read(3'd0, rd); check(rd == 0, "R9 start bit clears (below)", rd, 0);
    repeat (20) @(negedge clk);
    check(req_seen == n0 && !fl_req_valid && !mem_valid, "R9 no traffic", req_seen, n0);
    reg_read(3'd4, rd); check(rd == 0, "R9 no completion flag", rd, 0);
    check(irq == 0, "R9 no irq", irq, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule